// File: doc/BRIEF.md
# Memory Array Integrity Signature Checker

This block is a built-in self-test engine for a page-organised, flash-like storage array. Once software has unlocked test mode, the engine reads every page of the chosen blocks five times. On each reading it folds a different 32-bit slice of the page into a 32-bit multiple-input signature register (MISR). Software then reads the signature and compares it with a known-good value. A single result then covers stuck data bits, bad check bits and pages that the error-checking logic flags.

Each page is 128 data bits, seen as two 64-bit double words, plus one 8-bit check byte per double word. The engine drives the array address and samples the page on the same cycle. It evaluates the check bytes itself and gates each capture by a per-block select mask and an external lock mask. The control flow is as follows:
1. Write the password.
2. Write the select mask.
3. Optionally seed the signature.
4. Write the control word with enable set, choosing the addressing order with its second bit.
5. Poll the done output and read the signature.
6. Clear enable.

Top module: `array_sig_engine`

## Requirements
- R1: After synchronous reset, `test_mode`, `scan_busy`, `scan_done`, `rw_err` and `signature` are all zero.
- R2: A configuration write with `cfg_sel`=0 (password) and data 32'hA5C3_0F96 sets `test_mode`. Any other value clears it and clears enable. While `test_mode` is low, control writes (`cfg_sel`=2) are ignored and no scan starts.
- R3: A seed write (`cfg_sel`=3) made while no scan is running loads `cfg_wdata` into `signature` at that clock edge. Each capture updates the signature as {s[30:0], s[31]^s[21]^s[1]^s[0]} XOR w, where w is the captured 32-bit word.
- R4: A scan makes five full passes. Passes 1 to 4 capture page bits 31:0, 63:32, 95:64 and 127:96 respectively. Data and check bits are taken raw, without correction.
- R5: Pass 5 captures a zero-extended 20-bit word. Bits 7:0 hold the check byte of bits 63:0, bits 15:8 hold the check byte of bits 127:64, bit 16/17 hold the single/double flag of the low double word, and bit 18/19 hold the same flags for the high double word. Syndrome bit j is the check bit j XORed with every double-word bit k where k mod 8 = j. The single flag is set for an odd-weight syndrome, and the double flag for a nonzero even-weight syndrome.
- R6: A page is captured, and `arr_rd` pulses, only when its block's bit is set in the select mask (`cfg_sel`=1, bit b for block b) and is clear in `lock_mask`. Pages of other blocks leave the signature unchanged.
- R7: `arr_addr` = {block, page}. Passes run outermost, then blocks in ascending order, then pages. With control bit 1 set, pages are visited in ascending order. With it clear, pages are visited in bit-reversed index order.
- R8: Control bit 0 is enable. A scan starts on the cycle after enable is written to 1. `scan_done` rises exactly 5·B·P+1 clock edges after that write edge, where B is the block count and P is the page count. It stays high while enable stays set. Clearing enable returns the engine to idle, with `scan_done` and `scan_busy` low one cycle after the enable bit falls, and this also aborts a running scan.
- R9: A `host_rd` pulse while `test_mode` is high sets `rw_err`, which stays set until the correct password is written again. Outside test mode, `host_rd` has no effect.
- R10: Seed and select-mask writes made while `scan_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 password, 1 select mask, 2 control, 3 seed |
| cfg_wdata | input | 32 | Configuration write data |
| host_rd | input | 1 | Ordinary array read attempt |
| lock_mask | input | NUM_BLOCKS | Per-block lock, 1 = locked |
| arr_addr | output | BLK_W+PG_W | Array page address {block, page} |
| arr_rd | output | 1 | Page captured this cycle |
| arr_data | input | 128 | Raw page data for arr_addr |
| arr_ecc | input | 16 | Raw check bytes, [7:0] for bits 63:0 |
| test_mode | output | 1 | Test mode unlocked |
| scan_busy | output | 1 | Scan in progress |
| scan_done | output | 1 | Scan finished |
| rw_err | output | 1 | Ordinary read rejected during test mode |
| signature | output | 32 | Signature register |

## Verification
Two things can coincide in one cycle while a scan runs. A page capture can meet an ordinary host read, and it can also meet a software seed or select write. The bench starts a full scan and, in the middle of it, asserts `host_rd` during the same cycle as a seed write, then issues a select-mask write. It then judges three things: the final signature must equal the model value computed with the original seed and mask, the scan length must be unchanged, and `rw_err` must be set. Aborts, locked-but-selected blocks and injected single and double check-byte errors are covered by vectors whose expected signatures come from an independent software model of the array.

// File: rtl/array_sig_pkg.sv
package array_sig_pkg;

    localparam int SIG_W      = 32;
    localparam int PAGE_W     = 128;
    localparam int DW_W       = 64;
    localparam int CHK_W      = 8;
    localparam int ECC_W      = 2 * CHK_W;
    localparam int NUM_PASSES = 5;
    localparam int PASS_W     = $clog2(NUM_PASSES);
    localparam logic [SIG_W-1:0] UNLOCK_KEY = 32'hA5C3_0F96;

    typedef enum logic [1:0] {
        CFG_PASSWORD = 2'd0,
        CFG_SELECT   = 2'd1,
        CFG_CONTROL  = 2'd2,
        CFG_SEED     = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic             dbl_hi;
        logic             sgl_hi;
        logic             dbl_lo;
        logic             sgl_lo;
        logic [CHK_W-1:0] chk_hi;
        logic [CHK_W-1:0] chk_lo;
    } chk_word_t;

    typedef struct packed {
        logic dbl;
        logic sgl;
    } err_flags_t;

    // byte-fold parity: bit j covers every data bit whose index mod 8 is j
    function automatic logic [CHK_W-1:0] chk_fold(input logic [DW_W-1:0] d);
        logic [CHK_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < DW_W / CHK_W; i++) begin
            acc = acc ^ d[i*CHK_W +: CHK_W];
        end
        return acc;
    endfunction

    function automatic err_flags_t chk_eval(input logic [DW_W-1:0] d,
                                            input logic [CHK_W-1:0] c);
        logic [CHK_W-1:0] syn;
        err_flags_t       f;
        syn   = chk_fold(d) ^ c;
        f.sgl = ^syn;
        f.dbl = (syn != '0) && !(^syn);
        return f;
    endfunction

    function automatic logic [SIG_W-1:0] misr_step(input logic [SIG_W-1:0] s,
                                                   input logic [SIG_W-1:0] w);
        return {s[SIG_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]} ^ w;
    endfunction

endpackage

// File: rtl/array_sig_cfg.sv
module array_sig_cfg
    import array_sig_pkg::*;
#(
    parameter int NUM_BLOCKS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  cfg_sel_e              cfg_sel,
    input  logic [SIG_W-1:0]      cfg_wdata,
    input  logic                  host_rd,
    input  logic                  busy,
    output logic                  test_mode,
    output logic                  en,
    output logic                  seq_mode,
    output logic [NUM_BLOCKS-1:0] sel_mask,
    output logic                  rw_err,
    output logic                  seed_we,
    output logic [SIG_W-1:0]      seed_val
);

    logic pw_write;
    logic pw_match;

    assign pw_write = cfg_we && (cfg_sel == CFG_PASSWORD);
    assign pw_match = (cfg_wdata == UNLOCK_KEY);
    assign seed_we  = cfg_we && (cfg_sel == CFG_SEED) && !busy;
    assign seed_val = cfg_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            test_mode <= 1'b0;
            en        <= 1'b0;
            seq_mode  <= 1'b0;
            sel_mask  <= '0;
            rw_err    <= 1'b0;
        end else begin
            if (host_rd && test_mode) begin
                rw_err <= 1'b1;
            end
            if (cfg_we) begin
                unique case (cfg_sel)
                    CFG_PASSWORD: begin
                        if (pw_match) begin
                            test_mode <= 1'b1;
                            rw_err    <= 1'b0;
                        end else begin
                            test_mode <= 1'b0;
                            en        <= 1'b0;
                        end
                    end
                    CFG_SELECT: begin
                        if (!busy) begin
                            sel_mask <= cfg_wdata[NUM_BLOCKS-1:0];
                        end
                    end
                    CFG_CONTROL: begin
                        if (test_mode) begin
                            en       <= cfg_wdata[0];
                            seq_mode <= cfg_wdata[1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2: a control write outside test mode cannot raise enable
    p_ctrl_locked_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == CFG_CONTROL && !test_mode && !en) |=> !en);

    // R9: the read error flag only clears through a password write
    p_rwe_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (rw_err && !pw_write) |=> rw_err);

    // R10: the select mask is frozen while a scan runs
    p_sel_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(sel_mask));

endmodule

// File: rtl/array_sig_seq.sv
module array_sig_seq
    import array_sig_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4,
    parameter int PAGES_PER_BLOCK = 8,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int PG_W   = $clog2(PAGES_PER_BLOCK),
    localparam int ADDR_W = BLK_W + PG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  seq_mode,
    input  logic [NUM_BLOCKS-1:0] active,
    output logic [ADDR_W-1:0]     arr_addr,
    output logic                  cap_en,
    output logic [PASS_W-1:0]     pass_idx,
    output logic                  busy,
    output logic                  done
);

    localparam logic [BLK_W-1:0]  BLK_LAST  = BLK_W'(NUM_BLOCKS - 1);
    localparam logic [PG_W-1:0]   PG_LAST   = PG_W'(PAGES_PER_BLOCK - 1);
    localparam logic [PASS_W-1:0] PASS_LAST = PASS_W'(NUM_PASSES - 1);

    scan_state_e       state_q;
    logic [PASS_W-1:0] pass_q;
    logic [BLK_W-1:0]  blk_q;
    logic [PG_W-1:0]   pg_q;
    logic [PG_W-1:0]   pg_rev;
    logic [PG_W-1:0]   pg_phys;
    logic              seq_q;
    logic              pg_end, blk_end, pass_end;

    for (genvar i = 0; i < PG_W; i++) begin : g_rev
        assign pg_rev[i] = pg_q[PG_W-1-i];
    end

    assign pg_phys  = seq_q ? pg_q : pg_rev;
    assign arr_addr = {blk_q, pg_phys};
    assign pg_end   = (pg_q == PG_LAST);
    assign blk_end  = (blk_q == BLK_LAST);
    assign pass_end = (pass_q == PASS_LAST);
    assign cap_en   = (state_q == ST_SCAN) && en && active[blk_q];
    assign pass_idx = pass_q;
    assign busy     = (state_q == ST_SCAN);
    assign done     = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pass_q  <= '0;
            blk_q   <= '0;
            pg_q    <= '0;
            seq_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (en) begin
                        state_q <= ST_SCAN;
                        pass_q  <= '0;
                        blk_q   <= '0;
                        pg_q    <= '0;
                        seq_q   <= seq_mode;
                    end
                end
                ST_SCAN: begin
                    if (!en) begin
                        state_q <= ST_IDLE;
                    end else if (pg_end) begin
                        pg_q <= '0;
                        if (blk_end) begin
                            blk_q <= '0;
                            if (pass_end) begin
                                state_q <= ST_DONE;
                            end else begin
                                pass_q <= pass_q + 1'b1;
                            end
                        end else begin
                            blk_q <= blk_q + 1'b1;
                        end
                    end else begin
                        pg_q <= pg_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    if (!en) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7: ascending mode steps the page field by one within a block
    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && en && seq_q && !pg_end)
        |=> arr_addr[PG_W-1:0] == PG_W'($past(arr_addr[PG_W-1:0]) + 1'b1));

    // R4: the pass counter never exceeds the fifth pass
    p_pass_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> (pass_q <= PASS_LAST));

    // R8: done holds while enable stays set
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && en) |=> done);

    // R8: clearing enable releases done and busy
    p_done_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!en && (done || busy)) |=> (!done && !busy));

endmodule

// File: rtl/array_sig_misr.sv
module array_sig_misr
    import array_sig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_we,
    input  logic [SIG_W-1:0]  seed_val,
    input  logic              cap_en,
    input  logic [PASS_W-1:0] pass_idx,
    input  logic [PAGE_W-1:0] page_data,
    input  logic [ECC_W-1:0]  page_ecc,
    output logic [SIG_W-1:0]  sig
);

    err_flags_t       flg_lo, flg_hi;
    chk_word_t        chk_word;
    logic [SIG_W-1:0] cap_word;

    always_comb begin
        flg_lo          = chk_eval(page_data[DW_W-1:0], page_ecc[CHK_W-1:0]);
        flg_hi          = chk_eval(page_data[PAGE_W-1:DW_W], page_ecc[ECC_W-1:CHK_W]);
        chk_word.chk_lo = page_ecc[CHK_W-1:0];
        chk_word.chk_hi = page_ecc[ECC_W-1:CHK_W];
        chk_word.sgl_lo = flg_lo.sgl;
        chk_word.dbl_lo = flg_lo.dbl;
        chk_word.sgl_hi = flg_hi.sgl;
        chk_word.dbl_hi = flg_hi.dbl;
        unique case (pass_idx)
            PASS_W'(0): cap_word = page_data[31:0];
            PASS_W'(1): cap_word = page_data[63:32];
            PASS_W'(2): cap_word = page_data[95:64];
            PASS_W'(3): cap_word = page_data[127:96];
            default:    cap_word = SIG_W'(chk_word);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sig <= '0;
        end else if (seed_we) begin
            sig <= seed_val;
        end else if (cap_en) begin
            sig <= misr_step(sig, cap_word);
        end
    end

    // R6: without a capture or seed the signature holds
    p_sig_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !seed_we) |=> $stable(sig));

endmodule

// File: rtl/array_sig_engine.sv
module array_sig_engine
    import array_sig_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4,
    parameter int PAGES_PER_BLOCK = 8,
    localparam int BLK_W  = $clog2(NUM_BLOCKS),
    localparam int PG_W   = $clog2(PAGES_PER_BLOCK),
    localparam int ADDR_W = BLK_W + PG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [31:0]           cfg_wdata,
    input  logic                  host_rd,
    input  logic [NUM_BLOCKS-1:0] lock_mask,
    output logic [ADDR_W-1:0]     arr_addr,
    output logic                  arr_rd,
    input  logic [127:0]          arr_data,
    input  logic [15:0]           arr_ecc,
    output logic                  test_mode,
    output logic                  scan_busy,
    output logic                  scan_done,
    output logic                  rw_err,
    output logic [31:0]           signature
);

    logic                  en, seq_mode, seed_we, cap_en;
    logic [NUM_BLOCKS-1:0] sel_mask, active;
    logic [SIG_W-1:0]      seed_val;
    logic [PASS_W-1:0]     pass_idx;

    assign active = sel_mask & ~lock_mask;
    assign arr_rd = cap_en;

    array_sig_cfg #(.NUM_BLOCKS(NUM_BLOCKS)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel_e'(cfg_sel)),
        .cfg_wdata (cfg_wdata),
        .host_rd   (host_rd),
        .busy      (scan_busy),
        .test_mode (test_mode),
        .en        (en),
        .seq_mode  (seq_mode),
        .sel_mask  (sel_mask),
        .rw_err    (rw_err),
        .seed_we   (seed_we),
        .seed_val  (seed_val)
    );

    array_sig_seq #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .seq_mode (seq_mode),
        .active   (active),
        .arr_addr (arr_addr),
        .cap_en   (cap_en),
        .pass_idx (pass_idx),
        .busy     (scan_busy),
        .done     (scan_done)
    );

    array_sig_misr u_misr (
        .clk       (clk),
        .rst       (rst),
        .seed_we   (seed_we),
        .seed_val  (seed_val),
        .cap_en    (cap_en),
        .pass_idx  (pass_idx),
        .page_data (arr_data),
        .page_ecc  (arr_ecc),
        .sig       (signature)
    );

    // R6: the array is only read while test mode is unlocked
    p_rd_in_test_r6: assert property (@(posedge clk) disable iff (rst)
        arr_rd |-> test_mode);

    // R10: a seed load never lands on a capture cycle
    p_seed_vs_cap_r10: assert property (@(posedge clk) disable iff (rst)
        seed_we |-> !cap_en);

    // R9: outside test mode a host read leaves the error flag low
    p_rwe_off_r9: assert property (@(posedge clk) disable iff (rst)
        (!test_mode && !rw_err) |=> !rw_err);

endmodule

// File: tb/array_sig_engine_test.sv
module array_sig_engine_test;

    localparam int NB = 4;
    localparam int NP = 8;
    localparam int SCAN_CYC = 5 * NB * NP + 1;
    localparam logic [31:0] KEY = 32'hA5C3_0F96;
    // vector: seed, select, lock, seq, salt, injected page address
    localparam int NVEC = 6;
    localparam logic [53:0] VEC [NVEC] = '{
        {32'h0000_0000, 4'hF, 4'h0, 1'b1, 8'h11, 5'd31},
        {32'hFFFF_FFFF, 4'hF, 4'h0, 1'b0, 8'h11, 5'd3},
        {32'h1234_5678, 4'h5, 4'h4, 1'b0, 8'h7E, 5'd2},
        {32'hDEAD_BEEF, 4'hA, 4'h0, 1'b1, 8'h00, 5'd9},
        {32'h0BAD_F00D, 4'hF, 4'hF, 1'b0, 8'h5A, 5'd0},
        {32'h0000_0001, 4'h3, 4'h1, 1'b1, 8'hC3, 5'd12}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [31:0]   cfg_wdata = '0;
    logic          host_rd = 1'b0;
    logic [NB-1:0] lock_mask = '0;
    logic [4:0]    arr_addr;
    logic          arr_rd;
    logic [127:0]  arr_data;
    logic [15:0]   arr_ecc;
    logic          test_mode, scan_busy, scan_done, rw_err;
    logic [31:0]   signature;

    logic [7:0] salt = 8'h00;
    logic [4:0] inj  = 5'd0;
    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    array_sig_engine #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(NP)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .host_rd(host_rd), .lock_mask(lock_mask),
        .arr_addr(arr_addr), .arr_rd(arr_rd), .arr_data(arr_data),
        .arr_ecc(arr_ecc), .test_mode(test_mode), .scan_busy(scan_busy),
        .scan_done(scan_done), .rw_err(rw_err), .signature(signature)
    );

    function automatic logic [127:0] m_data(input logic [4:0] a, input logic [7:0] s);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) begin
            r[k*32 +: 32] = ((32'(a) + 32'd1) * 32'h9E37_79B1) ^ {4{s}} ^ (32'h1111_1111 << k);
        end
        return r;
    endfunction

    function automatic logic [7:0] m_gen(input logic [63:0] d);
        logic [7:0] e = '0;
        for (int k = 0; k < 64; k++) e[k % 8] = e[k % 8] ^ d[k];
        return e;
    endfunction

    function automatic logic [15:0] m_ecc(input logic [4:0] a, input logic [7:0] s,
                                          input logic [4:0] ia);
        logic [127:0] d = m_data(a, s);
        logic [7:0] e0 = m_gen(d[63:0]);
        logic [7:0] e1 = m_gen(d[127:64]);
        if (a == ia) begin
            e0 = e0 ^ 8'h01;
            e1 = e1 ^ 8'h06;
        end
        return {e1, e0};
    endfunction

    always_comb begin
        arr_data = m_data(arr_addr, salt);
        arr_ecc  = m_ecc(arr_addr, salt, inj);
    end

    always @(posedge clk) if (arr_rd) rd_cnt <= rd_cnt + 1;

    function automatic logic [31:0] exp_sig(input logic [31:0] seed, input logic [3:0] sel,
                                            input logic [3:0] lck, input logic sq,
                                            input logic [7:0] s, input logic [4:0] ia);
        logic [31:0] g = seed;
        for (int p = 0; p < 5; p++)
            for (int b = 0; b < NB; b++)
                for (int i = 0; i < NP; i++) begin
                    logic [2:0] iv = 3'(i);
                    logic [2:0] pg = sq ? iv : {iv[0], iv[1], iv[2]};
                    logic [4:0] a = {2'(b), pg};
                    logic [127:0] d = m_data(a, s);
                    logic [15:0] e = m_ecc(a, s, ia);
                    logic [7:0] y0 = m_gen(d[63:0]) ^ e[7:0];
                    logic [7:0] y1 = m_gen(d[127:64]) ^ e[15:8];
                    logic s0 = ($countones(y0) % 2) == 1;
                    logic s1 = ($countones(y1) % 2) == 1;
                    logic d0 = (y0 != 0) && !s0;
                    logic d1 = (y1 != 0) && !s1;
                    logic [31:0] w;
                    if (sel[b] && !lck[b]) begin
                        if (p < 4) w = d[p*32 +: 32];
                        else w = {12'b0, d1, s1, d0, s0, e[15:8], e[7:0]};
                        g = {g[30:0], g[31] ^ g[21] ^ g[1] ^ g[0]} ^ w;
                    end
                end
        return g;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!scan_done && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int r0;
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(test_mode == 0, "R1 test_mode", 32'(test_mode), 0);
        chk(scan_busy == 0, "R1 busy", 32'(scan_busy), 0);
        chk(scan_done == 0, "R1 done", 32'(scan_done), 0);
        chk(rw_err == 0, "R1 rw_err", 32'(rw_err), 0);
        chk(signature == 0, "R1 signature", signature, 0);

        // R2 control ignored while locked; R9 read outside test mode
        wr(2'd2, 32'h1);
        repeat (3) @(negedge clk);
        chk(scan_busy == 0 && scan_done == 0, "R2 no start when locked", 32'(scan_busy), 0);
        host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
        chk(rw_err == 0, "R9 read outside test mode", 32'(rw_err), 0);
        wr(2'd0, 32'h1234_0000);
        chk(test_mode == 0, "R2 wrong password", 32'(test_mode), 0);
        wr(2'd0, KEY);
        chk(test_mode == 1, "R2 correct password", 32'(test_mode), 1);
        wr(2'd0, KEY ^ 32'h1);
        chk(test_mode == 0, "R2 wrong password clears", 32'(test_mode), 0);
        wr(2'd0, KEY);

        // R3 seed in idle
        wr(2'd3, 32'hCAFE_F00D);
        chk(signature == 32'hCAFE_F00D, "R3 seed load", signature, 32'hCAFE_F00D);

        // vector table: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            logic [31:0] vs = VEC[v][53:22];
            logic [3:0]  vsel = VEC[v][21:18];
            logic [3:0]  vl = VEC[v][17:14];
            logic        vq = VEC[v][13];
            salt = VEC[v][12:5];
            inj = VEC[v][4:0];
            lock_mask = vl;
            wr(2'd3, vs);
            wr(2'd1, 32'(vsel));
            r0 = rd_cnt;
            wr(2'd2, {30'b0, vq, 1'b1});
            wait_done(n);
            e = exp_sig(vs, vsel, vl, vq, VEC[v][12:5], VEC[v][4:0]);
            chk(signature == e, "R4 R5 R7 signature", signature, e);
            chk(n == SCAN_CYC, "R8 scan length", 32'(n), 32'(SCAN_CYC));
            chk(rd_cnt - r0 == 5 * NP * $countones(vsel & ~vl), "R6 capture count",
                32'(rd_cnt - r0), 32'(5 * NP * $countones(vsel & ~vl)));
            @(negedge clk);
            chk(scan_done == 1, "R8 done holds", 32'(scan_done), 1);
            wr(2'd2, {30'b0, vq, 1'b0});
            @(negedge clk);
            chk(scan_done == 0 && scan_busy == 0, "R8 release", 32'(scan_done), 0);
        end

        // R10 + R9: seed/select writes and host read during a scan
        lock_mask = '0; salt = 8'h3C; inj = 5'd17;
        wr(2'd3, 32'h5555_AAAA);
        wr(2'd1, 32'hF);
        wr(2'd2, 32'h1);
        repeat (20) @(negedge clk);
        host_rd = 1'b1;
        wr(2'd3, 32'h0000_0000);
        host_rd = 1'b0;
        wr(2'd1, 32'h1);
        wait_done(n);
        e = exp_sig(32'h5555_AAAA, 4'hF, 4'h0, 1'b0, 8'h3C, 5'd17);
        chk(signature == e, "R10 writes ignored while busy", signature, e);
        chk(n == SCAN_CYC - 22, "R10 scan length kept", 32'(n), 32'(SCAN_CYC - 22));
        chk(rw_err == 1, "R9 read during test mode", 32'(rw_err), 1);
        wr(2'd2, 32'h0);
        wr(2'd0, KEY);
        chk(rw_err == 0, "R9 cleared by password", 32'(rw_err), 0);

        // R8 abort
        wr(2'd2, 32'h1);
        repeat (10) @(negedge clk);
        chk(scan_busy == 1, "R8 busy mid scan", 32'(scan_busy), 1);
        wr(2'd2, 32'h0);
        @(negedge clk);
        chk(scan_busy == 0 && scan_done == 0, "R8 abort", 32'(scan_busy), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule